// File: doc/BRIEF.md
# Vector Memory Synchronization Barrier Unit

This unit stands between a scalar issue stage and a vector engine that runs several memory instructions at once over separate load/store paths. It offers two barriers of different strength. The heavy one is a privileged drain read. Once issued, it holds the scalar side stalled until three things are true: every path counter and the scalar counter read zero, no vector access is still tracked, and every write issued has been acknowledged as visible. It then completes with a one-cycle done pulse that carries a return word of zero. Pending vector exceptions are held back from the scalar side while the drain is in progress, so they can neither fault it nor suspend it.

The light barrier affects vector accesses only. Each accepted barrier advances an epoch counter. Every vector access that is granted is recorded in a small tracking table, together with its address and the epoch it was issued in. A new access whose address matches a tracked access from a different, earlier epoch is held off until that access retires. Accesses to the same address within one epoch are not ordered against each other. The scalar side never sees this barrier.

Top module: `vmb_barrier_unit`

## Requirements
- R1: After reset, scalar_stall, drain_done, drain_reject and vbar_ack are 0, epoch is 0, the tracking table is empty, and vexc_report follows vec_exc_pending.
- R2: A drain_req with drain_priv=1, taken while no drain is in progress, raises scalar_stall from the next cycle. scalar_stall stays high until the cycle in which drain_done rises, and is low in that cycle.
- R3: drain_done is a one-cycle pulse. It rises in the cycle after the first cycle of the drain in which all NUM_PATHS fields of path_cnt (path p at bits p*CNT_W upward) are zero, scalar_cnt is zero, the write count is zero and the tracking table is empty.
- R4: The write count rises by one on each wr_issue pulse and falls by one on each wr_ack pulse. An ack when the count is zero has no effect. A drain cannot complete while the count is non-zero.
- R5: drain_data is zero whenever drain_done is high.
- R6: vexc_report is 0 whenever scalar_stall is 1, and otherwise equals vec_exc_pending. The drain completes whatever vec_exc_pending does.
- R7: A drain_req with drain_priv=0 starts no drain and produces no drain_done. It gives a one-cycle drain_reject pulse in the next cycle.
- R8: While a drain is in progress, drain_req and vbar_req are ignored: no second drain_done, vbar_ack stays 0 and epoch is unchanged.
- R9: An accepted vbar_req raises vbar_ack in the same cycle and increments epoch, modulo 2^EPOCH_W, in the next cycle. It does not raise scalar_stall.
- R10: vacc_grant rises in the same cycle as vacc_valid when a slot is free and there is no ordering conflict. vacc_slot then gives the lowest free slot index, and the access is recorded with the current epoch.
- R11: An access whose address equals that of a tracked access with a different epoch is refused until that access is retired. A match with the same epoch is not refused. A retire through vret_valid/vret_slot frees its slot for grants from the next cycle.
- R12: When all SLOTS slots are occupied, vacc_grant is 0.
- R13: vbar_req is refused (vbar_ack 0, epoch unchanged) while any tracked access carries epoch+1 modulo 2^EPOCH_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drain_req | input | 1 | Drain read issue, one-cycle request |
| drain_priv | input | 1 | Privilege of the issuing context |
| vbar_req | input | 1 | Vector-only barrier issue |
| vacc_valid | input | 1 | Vector access asks to proceed |
| vacc_addr | input | ADDR_W | Address of that access |
| vret_valid | input | 1 | A tracked access retires |
| vret_slot | input | SLOT_W | Slot of the retiring access |
| path_cnt | input | NUM_PATHS*CNT_W | Outstanding-access count per vector path |
| scalar_cnt | input | CNT_W | Outstanding scalar accesses |
| wr_issue | input | 1 | A write was issued |
| wr_ack | input | 1 | A write became visible to both sides |
| vec_exc_pending | input | 1 | Vector exception waiting to be reported |
| scalar_stall | output | 1 | Hold the scalar issue stage |
| drain_done | output | 1 | Drain read completes |
| drain_data | output | 32 | Return word of the drain read (zero) |
| drain_reject | output | 1 | Non-privileged drain attempt seen |
| vexc_report | output | 1 | Vector exception passed to the scalar side |
| vbar_ack | output | 1 | Vector barrier accepted |
| epoch | output | EPOCH_W | Current barrier epoch |
| vacc_grant | output | 1 | Vector access may proceed |
| vacc_slot | output | SLOT_W | Slot assigned to the granted access |

## Verification
A vector barrier can arrive in the same cycle as a drain request, or while a drain is in progress. The bench makes this happen by holding a path counter non-zero so the drain stays open, and then issuing vbar_req together with a second drain_req. Both must be ignored: vbar_ack is judged in the same cycle, the epoch value is judged one cycle later, and the scoreboard must see exactly one done pulse. A retire and a conflicting access in the same cycle are also driven together, and the grant must come only in the following cycle.

// File: rtl/vmb_pkg.sv
package vmb_pkg;

  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_WAIT = 1'b1
  } drain_st_e;

  // Saturating up/down counter step; a decrement at zero is dropped.
  function automatic int unsigned cnt_step(input int unsigned cur,
                                           input logic up,
                                           input logic dn,
                                           input int unsigned maxv);
    int unsigned nxt;
    nxt = cur;
    if (up && !dn) begin
      if (cur < maxv) nxt = cur + 1;
    end else if (dn && !up) begin
      if (cur > 0) nxt = cur - 1;
    end
    return nxt;
  endfunction

  // Epoch successor with wrap at 2^w.
  function automatic int unsigned epoch_after(input int unsigned e,
                                              input int unsigned w);
    return (e + 1) % (32'd1 << w);
  endfunction

endpackage

// File: rtl/vmb_drain_ctrl.sv
module vmb_drain_ctrl #(
  parameter int NUM_PATHS = 4,
  parameter int CNT_W     = 4,
  parameter int WR_W      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       drain_req,
  input  logic                       drain_priv,
  input  logic [NUM_PATHS*CNT_W-1:0] path_cnt,
  input  logic [CNT_W-1:0]           scalar_cnt,
  input  logic                       wr_issue,
  input  logic                       wr_ack,
  input  logic                       table_empty,
  input  logic                       vec_exc_pending,
  output logic                       drain_busy,
  output logic                       drain_accept,
  output logic                       all_quiet,
  output logic                       drain_done,
  output logic                       drain_reject,
  output logic                       vexc_report
);
  import vmb_pkg::*;

  localparam int unsigned WR_MAX = (32'd1 << WR_W) - 1;

  drain_st_e             st_q;
  logic [WR_W-1:0]       wr_cnt_q;
  logic [NUM_PATHS-1:0]  path_busy;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    assign path_busy[p] = |path_cnt[p*CNT_W +: CNT_W];
  end

  assign drain_busy   = (st_q == DR_WAIT);
  assign drain_accept = drain_req && drain_priv && (st_q == DR_IDLE);
  assign all_quiet    = (path_busy == '0) && (scalar_cnt == '0) &&
                        (wr_cnt_q == '0) && table_empty;
  assign vexc_report  = vec_exc_pending && !drain_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt_q <= '0;
    end else begin
      wr_cnt_q <= WR_W'(cnt_step(32'(wr_cnt_q), wr_issue, wr_ack, WR_MAX));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= DR_IDLE;
      drain_done   <= 1'b0;
      drain_reject <= 1'b0;
    end else begin
      drain_done   <= 1'b0;
      drain_reject <= drain_req && !drain_priv && (st_q == DR_IDLE);
      case (st_q)
        DR_IDLE: if (drain_accept) st_q <= DR_WAIT;
        DR_WAIT: if (all_quiet) begin
          st_q       <= DR_IDLE;
          drain_done <= 1'b1;
        end
        default: st_q <= DR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vmb_epoch_ctrl.sv
module vmb_epoch_ctrl #(
  parameter int EPOCH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vbar_req,
  input  logic               drain_busy,
  input  logic               wrap_hazard,
  output logic               vbar_ack,
  output logic [EPOCH_W-1:0] epoch
);
  import vmb_pkg::*;

  assign vbar_ack = vbar_req && !drain_busy && !wrap_hazard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epoch <= '0;
    end else if (vbar_ack) begin
      epoch <= EPOCH_W'(epoch_after(32'(epoch), EPOCH_W));
    end
  end

endmodule

// File: rtl/vmb_order_table.sv
module vmb_order_table #(
  parameter int SLOTS   = 4,
  parameter int ADDR_W  = 16,
  parameter int EPOCH_W = 3,
  parameter int SLOT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EPOCH_W-1:0] cur_epoch,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               ret_valid,
  input  logic [SLOT_W-1:0]  ret_slot,
  output logic               grant,
  output logic [SLOT_W-1:0]  grant_slot,
  output logic               conflict,
  output logic               table_empty,
  output logic               wrap_hazard
);
  import vmb_pkg::*;

  logic               vld_q  [SLOTS];
  logic [ADDR_W-1:0]  addr_q [SLOTS];
  logic [EPOCH_W-1:0] ep_q   [SLOTS];

  logic [SLOTS-1:0]   hit_old;
  logic [SLOTS-1:0]   is_free;
  logic [SLOTS-1:0]   ahead;
  logic [EPOCH_W-1:0] ep_next;

  assign ep_next = EPOCH_W'(epoch_after(32'(cur_epoch), EPOCH_W));

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign hit_old[g] = vld_q[g] && (addr_q[g] == req_addr) && (ep_q[g] != cur_epoch);
    assign is_free[g] = !vld_q[g];
    assign ahead[g]   = vld_q[g] && (ep_q[g] == ep_next);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        addr_q[g] <= '0;
        ep_q[g]   <= '0;
      end else if (grant && (grant_slot == SLOT_W'(g))) begin
        vld_q[g]  <= 1'b1;
        addr_q[g] <= req_addr;
        ep_q[g]   <= cur_epoch;
      end else if (ret_valid && (ret_slot == SLOT_W'(g))) begin
        vld_q[g]  <= 1'b0;
      end
    end
  end

  always_comb begin
    grant_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (is_free[i]) grant_slot = SLOT_W'(i);
    end
  end

  assign conflict    = |hit_old;
  assign table_empty = &is_free;
  assign wrap_hazard = |ahead;
  assign grant       = req_valid && !conflict && (|is_free);

endmodule

// File: rtl/vmb_barrier_unit.sv
module vmb_barrier_unit #(
  parameter int NUM_PATHS = 4,
  parameter int CNT_W     = 4,
  parameter int WR_W      = 4,
  parameter int ADDR_W    = 16,
  parameter int SLOTS     = 4,
  parameter int EPOCH_W   = 3,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       drain_req,
  input  logic                       drain_priv,
  input  logic                       vbar_req,
  input  logic                       vacc_valid,
  input  logic [ADDR_W-1:0]          vacc_addr,
  input  logic                       vret_valid,
  input  logic [SLOT_W-1:0]          vret_slot,
  input  logic [NUM_PATHS*CNT_W-1:0] path_cnt,
  input  logic [CNT_W-1:0]           scalar_cnt,
  input  logic                       wr_issue,
  input  logic                       wr_ack,
  input  logic                       vec_exc_pending,
  output logic                       scalar_stall,
  output logic                       drain_done,
  output logic [31:0]                drain_data,
  output logic                       drain_reject,
  output logic                       vexc_report,
  output logic                       vbar_ack,
  output logic [EPOCH_W-1:0]         epoch,
  output logic                       vacc_grant,
  output logic [SLOT_W-1:0]          vacc_slot
);

  // Internal events, named for the checker.
  logic drain_busy;
  logic drain_accept;
  logic all_quiet;
  logic table_empty;
  logic wrap_hazard;
  logic order_conflict;

  vmb_drain_ctrl #(
    .NUM_PATHS (NUM_PATHS),
    .CNT_W     (CNT_W),
    .WR_W      (WR_W)
  ) u_drain (
    .clk             (clk),
    .rst_n           (rst_n),
    .drain_req       (drain_req),
    .drain_priv      (drain_priv),
    .path_cnt        (path_cnt),
    .scalar_cnt      (scalar_cnt),
    .wr_issue        (wr_issue),
    .wr_ack          (wr_ack),
    .table_empty     (table_empty),
    .vec_exc_pending (vec_exc_pending),
    .drain_busy      (drain_busy),
    .drain_accept    (drain_accept),
    .all_quiet       (all_quiet),
    .drain_done      (drain_done),
    .drain_reject    (drain_reject),
    .vexc_report     (vexc_report)
  );

  vmb_epoch_ctrl #(
    .EPOCH_W (EPOCH_W)
  ) u_epoch (
    .clk         (clk),
    .rst_n       (rst_n),
    .vbar_req    (vbar_req),
    .drain_busy  (drain_busy),
    .wrap_hazard (wrap_hazard),
    .vbar_ack    (vbar_ack),
    .epoch       (epoch)
  );

  vmb_order_table #(
    .SLOTS   (SLOTS),
    .ADDR_W  (ADDR_W),
    .EPOCH_W (EPOCH_W),
    .SLOT_W  (SLOT_W)
  ) u_order (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_epoch   (epoch),
    .req_valid   (vacc_valid),
    .req_addr    (vacc_addr),
    .ret_valid   (vret_valid),
    .ret_slot    (vret_slot),
    .grant       (vacc_grant),
    .grant_slot  (vacc_slot),
    .conflict    (order_conflict),
    .table_empty (table_empty),
    .wrap_hazard (wrap_hazard)
  );

  assign scalar_stall = drain_busy;
  assign drain_data   = '0;

endmodule

// File: rtl/vmb_checker.sv
module vmb_checker #(
  parameter int EPOCH_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               drain_busy,
  input logic               drain_accept,
  input logic               all_quiet,
  input logic               scalar_stall,
  input logic               drain_done,
  input logic [31:0]        drain_data,
  input logic               vexc_report,
  input logic               vbar_ack,
  input logic [EPOCH_W-1:0] epoch,
  input logic               vacc_grant,
  input logic               order_conflict
);

  // R2
  stall_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_busy && !all_quiet) |=> scalar_stall);

  // R3
  done_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_busy && all_quiet) |=> (drain_done && !scalar_stall));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> !drain_done);

  // R3
  done_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_done) |-> $past(drain_busy));

  // R5
  data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> (drain_data == 32'd0));

  // R6
  exc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scalar_stall |-> !vexc_report);

  // R8
  no_reaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> (!drain_accept && !vbar_ack));

  // R9
  epoch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbar_ack |=> (epoch == EPOCH_W'($past(epoch) + 1'b1)));

  // R9
  vbar_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vbar_ack && !drain_accept) |=> !scalar_stall);

  // R9
  epoch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vbar_ack |=> $stable(epoch));

  // R11
  conflict_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    order_conflict |-> !vacc_grant);

endmodule

bind vmb_barrier_unit vmb_checker #(.EPOCH_W(EPOCH_W)) u_vmb_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .drain_busy     (drain_busy),
  .drain_accept   (drain_accept),
  .all_quiet      (all_quiet),
  .scalar_stall   (scalar_stall),
  .drain_done     (drain_done),
  .drain_data     (drain_data),
  .vexc_report    (vexc_report),
  .vbar_ack       (vbar_ack),
  .epoch          (epoch),
  .vacc_grant     (vacc_grant),
  .order_conflict (order_conflict)
);

// File: tb/vmb_barrier_unit_tb_top.sv
`timescale 1ns/1ps
module vmb_barrier_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drain_req = 1'b0, drain_priv = 1'b0, vbar_req = 1'b0;
  logic        vacc_valid = 1'b0;
  logic [15:0] vacc_addr = '0;
  logic        vret_valid = 1'b0;
  logic [1:0]  vret_slot = '0;
  logic [15:0] path_cnt = '0;
  logic [3:0]  scalar_cnt = '0;
  logic        wr_issue = 1'b0, wr_ack = 1'b0, vec_exc_pending = 1'b0;
  logic        scalar_stall, drain_done, drain_reject, vexc_report, vbar_ack, vacc_grant;
  logic [31:0] drain_data;
  logic [2:0]  epoch;
  logic [1:0]  vacc_slot;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_done[$];
  int exp_ep = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vmb_barrier_unit dut_i (
    .clk(clk), .rst_n(rst_n), .drain_req(drain_req), .drain_priv(drain_priv),
    .vbar_req(vbar_req), .vacc_valid(vacc_valid), .vacc_addr(vacc_addr),
    .vret_valid(vret_valid), .vret_slot(vret_slot), .path_cnt(path_cnt),
    .scalar_cnt(scalar_cnt), .wr_issue(wr_issue), .wr_ack(wr_ack),
    .vec_exc_pending(vec_exc_pending), .scalar_stall(scalar_stall),
    .drain_done(drain_done), .drain_data(drain_data), .drain_reject(drain_reject),
    .vexc_report(vexc_report), .vbar_ack(vbar_ack), .epoch(epoch),
    .vacc_grant(vacc_grant), .vacc_slot(vacc_slot)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Driver: issue a privileged drain and, when the completion cycle is
  // known in advance, push it to the scoreboard.
  task automatic issue_drain(input int done_delay);
    drain_req = 1'b1; drain_priv = 1'b1;
    if (done_delay > 0) exp_done.push_back(cyc + done_delay);
    tick();
    drain_req = 1'b0;
  endtask

  function automatic int ep_plus(input int e);
    return (e == 7) ? 0 : e + 1;
  endfunction

  // Monitor: compare each done pulse against the scoreboard. R3 R5
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (drain_done) begin
        if (exp_done.size() == 0) begin
          chk("R3 unexpected drain_done", 1, 0);
        end else begin
          chk("R3 drain_done cycle", cyc, exp_done.pop_front());
          chk("R5 drain_data", drain_data, 0);
        end
      end else if (exp_done.size() > 0 && cyc > exp_done[0]) begin
        chk("R3 missing drain_done", cyc, exp_done.pop_front());
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int base;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    #1;
    // R1 reset state
    chk("R1 scalar_stall", scalar_stall, 0);
    chk("R1 drain_done", drain_done, 0);
    chk("R1 drain_reject", drain_reject, 0);
    chk("R1 epoch", epoch, 0);
    chk("R1 vbar_ack", vbar_ack, 0);

    // R2 R3 idle drain completes two cycles after issue
    tick();
    issue_drain(2);
    #1 chk("R2 stall after issue", scalar_stall, 1);
    tick();
    #1 chk("R2 stall low on done", scalar_stall, 0);

    // R3 R6 drain held by a path counter, exceptions masked
    tick();
    path_cnt = 16'h0030; vec_exc_pending = 1'b1;
    #1 chk("R6 report when idle", vexc_report, 1);
    tick();
    issue_drain(0);
    for (int k = 0; k < 3; k++) begin
      #1 chk("R3 stall while path busy", scalar_stall, 1);
      chk("R6 report masked", vexc_report, 0);
      tick();
    end
    path_cnt = '0;
    exp_done.push_back(cyc + 1);
    tick();
    #1 chk("R6 report after done", vexc_report, 1);
    vec_exc_pending = 1'b0;

    // R4 write visibility count
    tick(); wr_issue = 1'b1;
    tick(); tick(); wr_issue = 1'b0;
    issue_drain(0);
    wr_ack = 1'b1;
    tick(); wr_ack = 1'b0;
    #1 chk("R4 stall with one write open", scalar_stall, 1);
    tick(); wr_ack = 1'b1;
    exp_done.push_back(cyc + 2);
    tick(); wr_ack = 1'b0;
    #1 chk("R4 stall until count seen zero", scalar_stall, 1);
    tick();
    // R4 ack at zero ignored
    tick(); wr_ack = 1'b1;
    tick(); wr_ack = 1'b0;
    tick();
    issue_drain(2);
    tick();

    // R3 scalar counter holds the drain
    tick(); scalar_cnt = 4'd2;
    issue_drain(0);
    tick();
    #1 chk("R3 stall with scalar busy", scalar_stall, 1);
    scalar_cnt = '0;
    exp_done.push_back(cyc + 1);
    tick(); tick();

    // R7 non-privileged attempt
    drain_req = 1'b1; drain_priv = 1'b0;
    tick(); drain_req = 1'b0;
    #1 chk("R7 reject pulse", drain_reject, 1);
    chk("R7 no stall", scalar_stall, 0);
    tick();
    #1 chk("R7 reject one cycle", drain_reject, 0);

    // R8 requests ignored during a drain
    path_cnt = 16'h1000;
    issue_drain(0);
    vbar_req = 1'b1; drain_req = 1'b1; drain_priv = 1'b1;
    #1 chk("R8 vbar_ack while busy", vbar_ack, 0);
    tick(); vbar_req = 1'b0; drain_req = 1'b0;
    #1 chk("R8 epoch unchanged", epoch, exp_ep);
    path_cnt = '0;
    exp_done.push_back(cyc + 1);
    tick(); tick(); tick();

    // R9 vector barrier
    vbar_req = 1'b1;
    #1 chk("R9 vbar_ack", vbar_ack, 1);
    tick(); vbar_req = 1'b0; exp_ep = ep_plus(exp_ep);
    #1 chk("R9 epoch step", epoch, exp_ep);
    chk("R9 no stall", scalar_stall, 0);

    // R10 R11 R12 ordering table
    tick(); vacc_valid = 1'b1; vacc_addr = 16'h0040;
    #1 chk("R10 grant", vacc_grant, 1);
    chk("R10 slot", vacc_slot, 0);
    tick();
    #1 chk("R11 same epoch not refused", vacc_grant, 1);
    chk("R10 slot next", vacc_slot, 1);
    tick(); vacc_valid = 1'b0; vbar_req = 1'b1;
    tick(); vbar_req = 1'b0; exp_ep = ep_plus(exp_ep);
    vacc_valid = 1'b1; vacc_addr = 16'h0040;
    #1 chk("R11 older epoch match refused", vacc_grant, 0);
    vacc_addr = 16'h0080;
    #1 chk("R11 other address granted", vacc_grant, 1);
    chk("R10 slot two", vacc_slot, 2);
    tick(); vacc_addr = 16'h00C0;
    #1 chk("R10 slot three", vacc_slot, 3);
    tick(); vacc_addr = 16'h0100;
    #1 chk("R12 full refused", vacc_grant, 0);
    tick(); vacc_valid = 1'b0; vret_valid = 1'b1; vret_slot = 2'd0;
    tick(); vret_slot = 2'd1; vacc_valid = 1'b1; vacc_addr = 16'h0040;
    #1 chk("R11 refused in retire cycle", vacc_grant, 0);
    tick(); vret_valid = 1'b0;
    #1 chk("R11 granted after retire", vacc_grant, 1);
    chk("R10 lowest free slot", vacc_slot, 0);
    tick(); vacc_valid = 1'b0;

    // R13 alias guard: slots hold epoch exp_ep
    base = exp_ep;
    for (int k = 0; k < 7; k++) begin
      vbar_req = 1'b1;
      #1 chk("R13 barrier accepted", vbar_ack, 1);
      tick(); exp_ep = ep_plus(exp_ep);
    end
    #1 chk("R13 barrier refused at alias", vbar_ack, 0);
    tick(); vbar_req = 1'b0;
    #1 chk("R13 epoch held", epoch, exp_ep);
    chk("R13 epoch distance", (base + 7) % 8, exp_ep);

    // R3 drain waits for tracked accesses
    issue_drain(0);
    tick();
    #1 chk("R3 stall with table busy", scalar_stall, 1);
    vret_valid = 1'b1; vret_slot = 2'd0;
    tick(); vret_slot = 2'd2;
    tick(); vret_slot = 2'd3;
    exp_done.push_back(cyc + 2);
    tick(); vret_valid = 1'b0;
    repeat (5) tick();
    chk("R3 scoreboard drained", exp_done.size(), 0);
    summary();
  end

endmodule